// File: doc/BRIEF.md
# Row Logic Interconnect with Global Line Enables

This block joins a row of four digital row signals to sixteen shared global output lines, split into eight even lines and eight odd lines. Each row output goes through its own two-input lookup table. Input A of table x is row signal x. Input B is row signal (x+1) mod 4. Four configuration bits choose the function of each table.

A second 16-bit configuration sets which global lines each table result may drive. Row output x can reach a fixed set of four lines: even x, even x+4, odd x and odd x+4. Each line has its own enable. The block does not use tri-state drivers. It gives every line an enable output and a data output, and the data output is forced low while the enable is low.

The block also passes global inputs into the row. For each input, one select bit chooses between the raw value and a copy that has been resynchronized to the system clock through two flops. Software sets all of this through a simple byte-wide write port. Every configuration register resets to zero.

Top module: `rowlink_xbar`

## Requirements
- R1: While reset is asserted, and after it until the first write, every line enable and line data output is 0, and `row_in_o` equals `gin_i`, because the raw path is selected.
- R2: The result of table x is cfg[3 - 2*A - B], with A = `row_i[x]` and B = `row_i[(x+1)%4]`. So the truth-table entry for AB=00 is bit 3 and the entry for AB=11 is bit 0. Examples: 0001 gives AND, 0111 gives OR, 0110 gives XOR, 1000 gives NOR, 0000 gives constant 0 and 1111 gives constant 1.
- R3: Row x has enable nibble bits [4x+3:4x]. Bit 0 enables even line x, bit 1 enables even line x+4, bit 2 enables odd line x, and bit 3 enables odd line x+4.
- R4: A line data output equals its table result when that line's enable is 1, and is 0 when the enable is 0.
- R5: The register map is as follows. Address 0 holds table 0 in bits [3:0] and table 1 in bits [7:4]. Address 1 holds tables 2 and 3 in the same way. Address 2 holds enable nibbles for rows 0 and 1, row 0 in the low nibble. Address 3 holds enable nibbles for rows 2 and 3. Address 4 bits [3:0] are the per-input sync selects, where 1 means synchronized. A write takes effect at the clock edge where `wr_en_i` is sampled high, and outputs hold their values with no write.
- R6: Writes to addresses 5 to 7 change no output.
- R7: When an input's select bit is 1, `row_in_o` for that input changes on the second rising edge after `gin_i` changes.
- R8: When an input's select bit is 0, `row_in_o` for that input follows `gin_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration register address |
| wr_data_i | input | 8 | Configuration write data |
| row_i | input | 4 | Row signals that feed the tables |
| gin_i | input | 4 | Global inputs entering the row |
| row_in_o | output | 4 | Global inputs after the raw or synchronized select |
| goe_en_o | output | 8 | Drive enables for the even global lines |
| goe_dat_o | output | 8 | Data for the even global lines |
| goo_en_o | output | 8 | Drive enables for the odd global lines |
| goo_dat_o | output | 8 | Data for the odd global lines |

## Verification
The assertions check these properties on every cycle:
- no line carries data while its enable is low;
- enables stay put unless a write was sampled, and a write to an unused address never moves them;
- a synchronized input equals the value from two edges earlier;
- a raw input tracks its pin.

Only the bench scenarios can show the following. The full table decode, covering all sixteen codes under every AB pair. The exact enable-bit-to-line mapping. The byte and nibble placement of each register. The exact edge on which a synchronized transition first appears.

// File: rtl/rowlink_pkg.sv
package rowlink_pkg;
  localparam int LUT_W = 4;
  localparam int OE_W  = 4;

  typedef enum logic [1:0] {
    OE_EVEN_LO = 2'd0,
    OE_EVEN_HI = 2'd1,
    OE_ODD_LO  = 2'd2,
    OE_ODD_HI  = 2'd3
  } oe_bit_e;
endpackage

// File: rtl/rowlink_cfg.sv
module rowlink_cfg
  import rowlink_pkg::*;
#(
  parameter int N_ROW = 4,
  parameter int N_GIN = 4,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [N_ROW*LUT_W-1:0] lut_o,
  output logic [N_ROW*OE_W-1:0]  oe_o,
  output logic [N_GIN-1:0]       sel_o
);
  localparam int N_LREG  = (N_ROW*LUT_W)/DW;
  localparam int N_OREG  = (N_ROW*OE_W)/DW;
  localparam int SEL_ADR = N_LREG + N_OREG;

  logic [N_ROW*LUT_W-1:0] lut_q;
  logic [N_ROW*OE_W-1:0]  oe_q;
  logic [N_GIN-1:0]       sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lut_q <= '0;
      oe_q  <= '0;
      sel_q <= '0;
    end else if (wr_en_i) begin
      for (int r = 0; r < N_LREG; r++)
        if (wr_addr_i == AW'(r)) lut_q[r*DW +: DW] <= wr_data_i;
      for (int r = 0; r < N_OREG; r++)
        if (wr_addr_i == AW'(N_LREG + r)) oe_q[r*DW +: DW] <= wr_data_i;
      if (wr_addr_i == AW'(SEL_ADR)) sel_q <= wr_data_i[N_GIN-1:0];
    end
  end

  assign lut_o = lut_q;
  assign oe_o  = oe_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/rowlink_lut.sv
module rowlink_lut
  import rowlink_pkg::*;
(
  input  logic [LUT_W-1:0] cfg_i,
  input  logic             a_i,
  input  logic             b_i,
  output logic             y_o
);
  // AB=00 selects bit 3, AB=11 selects bit 0
  logic [1:0] idx;
  assign idx = 2'd3 - {a_i, b_i};
  assign y_o = cfg_i[idx];
endmodule

// File: rtl/rowlink_sync.sv
module rowlink_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rowlink_xbar.sv
module rowlink_xbar
  import rowlink_pkg::*;
#(
  parameter int N_ROW = 4,
  parameter int N_GIN = 4,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [N_ROW-1:0]   row_i,
  input  logic [N_GIN-1:0]   gin_i,
  output logic [N_GIN-1:0]   row_in_o,
  output logic [2*N_ROW-1:0] goe_en_o,
  output logic [2*N_ROW-1:0] goe_dat_o,
  output logic [2*N_ROW-1:0] goo_en_o,
  output logic [2*N_ROW-1:0] goo_dat_o
);
  localparam int N_LINE = 2*N_ROW;

  logic [N_ROW*LUT_W-1:0] lut_cfg;
  logic [N_ROW*OE_W-1:0]  oe_cfg;
  logic [N_GIN-1:0]       sync_sel;
  logic [N_GIN-1:0]       gin_sync;
  logic [N_ROW-1:0]       lut_y;

  rowlink_cfg #(.N_ROW(N_ROW), .N_GIN(N_GIN), .DW(DW), .AW(AW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lut_o     (lut_cfg),
    .oe_o      (oe_cfg),
    .sel_o     (sync_sel)
  );

  rowlink_sync #(.W(N_GIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gin_i),
    .q_o    (gin_sync)
  );

  always_comb begin
    for (int i = 0; i < N_GIN; i++)
      row_in_o[i] = sync_sel[i] ? gin_sync[i] : gin_i[i];
  end

  for (genvar x = 0; x < N_ROW; x++) begin : g_row
    localparam int XN = (x + 1) % N_ROW;
    logic [OE_W-1:0] en;

    rowlink_lut u_lut (
      .cfg_i (lut_cfg[x*LUT_W +: LUT_W]),
      .a_i   (row_i[x]),
      .b_i   (row_i[XN]),
      .y_o   (lut_y[x])
    );

    assign en = oe_cfg[x*OE_W +: OE_W];

    assign goe_en_o[x]         = en[OE_EVEN_LO];
    assign goe_en_o[x+N_ROW]   = en[OE_EVEN_HI];
    assign goo_en_o[x]         = en[OE_ODD_LO];
    assign goo_en_o[x+N_ROW]   = en[OE_ODD_HI];
    assign goe_dat_o[x]        = en[OE_EVEN_LO] & lut_y[x];
    assign goe_dat_o[x+N_ROW]  = en[OE_EVEN_HI] & lut_y[x];
    assign goo_dat_o[x]        = en[OE_ODD_LO]  & lut_y[x];
    assign goo_dat_o[x+N_ROW]  = en[OE_ODD_HI]  & lut_y[x];
  end

  if (N_LINE != 2*N_ROW) begin : g_bad_cfg
    initial $error("line count must be twice row count");
  end
endmodule

// File: rtl/rowlink_chk.sv
module rowlink_chk #(
  parameter int N_ROW = 4,
  parameter int N_GIN = 4,
  parameter int AW    = 3,
  parameter int FIRST_FREE = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [N_GIN-1:0]   gin_i,
  input logic [N_GIN-1:0]   sel_i,
  input logic [N_GIN-1:0]   row_in_o,
  input logic [2*N_ROW-1:0] goe_en_o,
  input logic [2*N_ROW-1:0] goe_dat_o,
  input logic [2*N_ROW-1:0] goo_en_o,
  input logic [2*N_ROW-1:0] goo_dat_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_DAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((goe_dat_o & ~goe_en_o) | (goo_dat_o & ~goo_en_o)) == '0)); // R4

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable({goe_en_o, goo_en_o})); // R5

  AST_FREE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && (wr_addr_i >= AW'(FIRST_FREE))) |-> $stable({goe_en_o, goo_en_o})); // R6

  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> ((row_in_o & sel_i) == ($past(gin_i, 2) & sel_i))); // R7

  AST_RAW_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_in_o & ~sel_i) == (gin_i & ~sel_i))); // R8
endmodule

bind rowlink_xbar rowlink_chk #(
  .N_ROW(N_ROW), .N_GIN(N_GIN), .AW(AW), .FIRST_FREE(4*N_ROW*2/DW + 1)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .gin_i     (gin_i),
  .sel_i     (sync_sel),
  .row_in_o  (row_in_o),
  .goe_en_o  (goe_en_o),
  .goe_dat_o (goe_dat_o),
  .goo_en_o  (goo_en_o),
  .goo_dat_o (goo_dat_o)
);

// File: tb/sim_rowlink_xbar.sv
module sim_rowlink_xbar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] row = '0;
  logic [3:0] gin = '0;
  logic [3:0] row_in;
  logic [7:0] goe_en, goe_dat, goo_en, goo_dat;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] lut_m = '0;
  logic [15:0] oe_m  = '0;
  logic [3:0]  sel_m = '0;

  always #10 clk = ~clk;

  rowlink_xbar u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .row_i(row), .gin_i(gin), .row_in_o(row_in),
    .goe_en_o(goe_en), .goe_dat_o(goe_dat), .goo_en_o(goo_en), .goo_dat_o(goo_dat)
  );

  function automatic logic lut_ref(logic [3:0] c, logic a, logic b);
    int k;
    k = 3 - 2*int'(a) - int'(b);
    return c[k];
  endfunction

  // {goo_dat, goo_en, goe_dat, goe_en}
  function automatic logic [31:0] exp_lines(logic [3:0] r);
    logic [7:0] ee, ed, oe, od;
    ee = '0; ed = '0; oe = '0; od = '0;
    for (int x = 0; x < 4; x++) begin
      logic y;
      y = lut_ref(lut_m[4*x +: 4], r[x], r[(x+1)%4]);
      ee[x] = oe_m[4*x];   ed[x] = oe_m[4*x] & y;
      ee[x+4] = oe_m[4*x+1]; ed[x+4] = oe_m[4*x+1] & y;
      oe[x] = oe_m[4*x+2]; od[x] = oe_m[4*x+2] & y;
      oe[x+4] = oe_m[4*x+3]; od[x+4] = oe_m[4*x+3] & y;
    end
    return {od, oe, ed, ee};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_lines(string req);
    check(req, {goo_dat, goo_en, goe_dat, goe_en}, exp_lines(row));
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: lut_m[7:0]  = d;
      3'd1: lut_m[15:8] = d;
      3'd2: oe_m[7:0]   = d;
      3'd3: oe_m[15:8]  = d;
      3'd4: sel_m       = d[3:0];
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    row = 4'hF; gin = 4'hA;
    #35;
    check("R1 reset lines", {goo_dat, goo_en, goe_dat, goe_en}, '0);
    check("R1 reset raw", {28'd0, row_in}, {28'd0, gin});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset lines", {goo_dat, goo_en, goe_dat, goe_en}, '0);
    check("R1 after reset raw", {28'd0, row_in}, {28'd0, gin});

    // R5: write not visible before the edge, visible after
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hFF;
    #1 check("R5 pre-edge", {24'd0, goe_en}, '0);
    @(negedge clk);
    wr_en = 1'b0; oe_m[7:0] = 8'hFF;
    check("R5 post-edge", {24'd0, goe_en}, 32'h33);
    wr(3'd3, 8'hFF);

    // R2 R4: every code against every AB
    for (int c = 0; c < 16; c++) begin
      wr(3'd0, {c[3:0], c[3:0]});
      wr(3'd1, {c[3:0], c[3:0]});
      for (int p = 0; p < 16; p++) begin
        row = p[3:0];
        #2;
        check("R2 lut code", {31'd0, goe_dat[0]}, {31'd0, lut_ref(c[3:0], row[0], row[1])});
        chk_lines("R2 R4 lines");
      end
    end

    // R3: single enable bit per line
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    for (int b = 0; b < 16; b++) begin
      wr(3'd2, (b < 8) ? 8'(1 << b) : 8'h00);
      wr(3'd3, (b >= 8) ? 8'(1 << (b-8)) : 8'h00);
      #2 chk_lines("R3 enable map");
    end

    // R6: unused addresses
    wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF);
      #2 chk_lines("R6 free addr");
    end

    // random mix: R2 R3 R4 R5 R6
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2 == 0) wr(3'($urandom % 8), 8'($urandom));
      row = 4'($urandom);
      #2 chk_lines("R5 random");
    end

    // R7: synchronized path latency
    wr(3'd4, 8'h0F);
    gin = 4'h0;
    repeat (3) @(negedge clk);
    gin = 4'b1011;
    #1 check("R7 before edge", {28'd0, row_in}, 32'h0);
    @(posedge clk); #1;
    check("R7 first edge", {28'd0, row_in}, 32'h0);
    @(posedge clk); #1;
    check("R7 second edge", {28'd0, row_in}, 32'hB);

    // R8 raw path, mixed with R7
    wr(3'd4, 8'h03);
    repeat (2) @(negedge clk);
    gin = 4'b0100;
    #1 check("R8 raw immediate", {28'd0, row_in}, {28'd0, 4'b0111});
    @(posedge clk); #1;
    check("R7 mixed first edge", {28'd0, row_in}, {28'd0, 4'b0111});
    @(posedge clk); #1;
    check("R7 mixed second edge", {28'd0, row_in}, {28'd0, 4'b0100});
    wr(3'd4, 8'h00);
    gin = 4'b1001;
    #1 check("R8 raw all", {28'd0, row_in}, 32'h9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule